// File: doc/BRIEF.md
# Programmed-I/O Disk Command Sequencer

This block sits on the host side of an IDE/ATA-style task-file register interface. It runs one programmed-I/O sector read or write at a time. A request carries a direction, a drive select (primary or secondary), a 28-bit logical block address and an 8-bit sector count. The sequencer masks device interrupts through the device control register, then waits for the drive to be idle and ready. It loads the parameter registers and issues the opcode. It then moves each 512-byte sector as 16-bit words through the data port, and checks the final status.

The device side is a simple register port: one access per cycle, with a 10-bit address, a read or write strobe, a 16-bit write value and a 16-bit read value that is sampled in the same cycle. The user side streams read words out on a one-cycle valid. Write words are taken from an input with a one-cycle take strobe. Completion is a single-cycle done pulse or a single-cycle error pulse. The error pulse carries a kind code and, for a drive-reported error, the contents of the drive's error register.

Top module: `pio_disk_seq`

## Requirements
- R1: After a request is accepted (reqValid while reqReady), the first device access writes 0x0A to address 0x3F6: bit 3 set, bit 1 set to mask interrupts, and bit 2 (reset) clear.
- R2: Before any parameter write, the block reads status at 0x1F7 every cycle until bit 7 (BUSY) is 0 and bit 6 (READY) is 1.
- R3: The parameter writes follow, one per cycle, in this order: the sector count to 0x1F2; LBA bits 7:0, 15:8 and 23:16 to 0x1F3, 0x1F4 and 0x1F5; 0xE0 | drive<<4 | LBA[27:24] to 0x1F6; then the opcode to 0x1F7, which is 0x20 for a read and 0x30 for a write.
- R4: Before each sector, status is polled until BUSY is 0 and bit 3 (DRQ) is 1. Then exactly WORDS_PER_SECTOR consecutive data-port accesses at 0x1F0 follow.
- R5: For a read, each data word appears on rdData with rdValid high, in device order. For a write, wrTake is high in the cycle that wrData is driven onto devWdata at 0x1F0.
- R6: A sector count of 0 transfers 256 sectors. The raw value 0 is still written to 0x1F2.
- R7: After the last sector, status is polled until BUSY is 0. If bit 0 (ERROR) and bit 5 (FAULT) are both clear, done pulses in the next cycle.
- R8: If ERROR is set in any status read after the opcode, the block reads 0x1F1 in the next cycle and moves no data. ERROR takes precedence over DRQ and FAULT. err then pulses with errKind 0 and errDetail equal to the value read.
- R9: If FAULT is set without ERROR after the opcode, err pulses with errKind 1 and errDetail 0.
- R10: If TIMEOUT_POLLS consecutive status reads in one wait all fail, err pulses with errKind 2. A success on the last permitted read lets the sequence proceed.
- R11: done and err are single-cycle and never high together. reqReady is high only when no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Idle, a request is accepted this cycle |
| reqWrite | input | 1 | 1 = write to disk, 0 = read |
| reqDrive | input | 1 | 0 = primary drive, 1 = secondary |
| reqLba | input | 28 | Logical block address |
| reqCount | input | 8 | Sector count, 0 means 256 |
| wrData | input | 16 | Write word to send |
| wrTake | output | 1 | wrData consumed this cycle |
| rdData | output | 16 | Read word |
| rdValid | output | 1 | rdData valid this cycle |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Error completion pulse |
| errKind | output | 2 | 0 drive error, 1 fault, 2 timeout |
| errDetail | output | 8 | Drive error register value |
| devAddr | output | 10 | Device register address |
| devWr | output | 1 | Device register write |
| devRd | output | 1 | Device register read |
| devWdata | output | 16 | Device write value |
| devRdata | input | 16 | Device read value, same cycle |

## Verification
Two collisions can fall in one status-read cycle. The first is a poll that succeeds on the very read where the timeout limit expires. The bench provokes it by holding BUSY for exactly TIMEOUT_POLLS-1 reads, and expects the sequence to continue rather than abort. The second is a status value with ERROR and DRQ set together right after the opcode. The bench expects the error register read on the next cycle, no data-port access and an error pulse carrying the device's error value. A device model in the bench drives each scripted status and data value, and every device access is compared on every clock against an expected access list built from the requirements.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_ERRREG, SEL_COUNT, SEL_LBA0, SEL_LBA1,
    SEL_LBA2, SEL_HEAD, SEL_CMDSTAT, SEL_DEVCTL
  } regSel_e;

  typedef enum logic [1:0] {
    KIND_DRIVE   = 2'd0,
    KIND_FAULT   = 2'd1,
    KIND_TIMEOUT = 2'd2
  } errKind_e;

  // status bit positions
  localparam int ST_BUSY  = 7;
  localparam int ST_READY = 6;
  localparam int ST_FAULT = 5;
  localparam int ST_DRQ   = 3;
  localparam int ST_ERROR = 0;

  localparam logic [7:0] OPC_READ   = 8'h20;
  localparam logic [7:0] OPC_WRITE  = 8'h30;
  localparam logic [7:0] DEVCTL_VAL = 8'h0A;

  localparam logic [9:0] ADR_DATA   = 10'h1F0;
  localparam logic [9:0] ADR_ERRREG = 10'h1F1;
  localparam logic [9:0] ADR_CMDST  = 10'h1F7;

  typedef struct packed {
    logic     load;      // latch request
    logic     access;    // device access this cycle
    logic     isWrite;   // access direction
    regSel_e  sel;       // register selected
    logic     tick;      // failed poll, advance timer
    logic     wordStep;  // data word moved
    logic     finishOk;
    logic     finishErr;
    errKind_e kind;
    logic     grabErr;   // capture device read value as detail
  } strobe_t;

  function automatic logic [9:0] selAddr(regSel_e s);
    case (s)
      SEL_DATA:    selAddr = 10'h1F0;
      SEL_ERRREG:  selAddr = 10'h1F1;
      SEL_COUNT:   selAddr = 10'h1F2;
      SEL_LBA0:    selAddr = 10'h1F3;
      SEL_LBA1:    selAddr = 10'h1F4;
      SEL_LBA2:    selAddr = 10'h1F5;
      SEL_HEAD:    selAddr = 10'h1F6;
      SEL_CMDSTAT: selAddr = 10'h1F7;
      SEL_DEVCTL:  selAddr = 10'h3F6;
      default:     selAddr = 10'h1F0;
    endcase
  endfunction

endpackage

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       curWrite,
  input  logic [7:0] status,
  input  logic       wordLast,
  input  logic       sectorLast,
  input  logic       timerLast,
  output logic       idle,
  output strobe_t    st
);

  typedef enum logic [3:0] {
    S_IDLE, S_DEVCTL, S_WAITRDY, S_COUNT, S_LBA0, S_LBA1, S_LBA2,
    S_HEAD, S_CMD, S_WAITDRQ, S_XFER, S_WAITEND, S_GETERR
  } state_e;

  state_e state, nextState;

  logic busy, ready, drq, errBit, fault;
  assign busy   = status[ST_BUSY];
  assign ready  = status[ST_READY];
  assign drq    = status[ST_DRQ];
  assign errBit = status[ST_ERROR];
  assign fault  = status[ST_FAULT];

  assign idle = (state == S_IDLE);

  always_comb begin
    st        = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          st.load   = 1'b1;
          nextState = S_DEVCTL;
        end
      end
      S_DEVCTL: begin
        st.access = 1'b1; st.isWrite = 1'b1; st.sel = SEL_DEVCTL;
        nextState = S_WAITRDY;
      end
      S_WAITRDY: begin
        st.access = 1'b1; st.sel = SEL_CMDSTAT;
        if (!busy && ready) begin
          nextState = S_COUNT;
        end else if (timerLast) begin
          st.finishErr = 1'b1; st.kind = KIND_TIMEOUT;
          nextState = S_IDLE;
        end else begin
          st.tick = 1'b1;
        end
      end
      S_COUNT: begin
        st.access = 1'b1; st.isWrite = 1'b1; st.sel = SEL_COUNT;
        nextState = S_LBA0;
      end
      S_LBA0: begin
        st.access = 1'b1; st.isWrite = 1'b1; st.sel = SEL_LBA0;
        nextState = S_LBA1;
      end
      S_LBA1: begin
        st.access = 1'b1; st.isWrite = 1'b1; st.sel = SEL_LBA1;
        nextState = S_LBA2;
      end
      S_LBA2: begin
        st.access = 1'b1; st.isWrite = 1'b1; st.sel = SEL_LBA2;
        nextState = S_HEAD;
      end
      S_HEAD: begin
        st.access = 1'b1; st.isWrite = 1'b1; st.sel = SEL_HEAD;
        nextState = S_CMD;
      end
      S_CMD: begin
        st.access = 1'b1; st.isWrite = 1'b1; st.sel = SEL_CMDSTAT;
        nextState = S_WAITDRQ;
      end
      S_WAITDRQ: begin
        st.access = 1'b1; st.sel = SEL_CMDSTAT;
        if (!busy && errBit) begin
          nextState = S_GETERR;
        end else if (!busy && fault) begin
          st.finishErr = 1'b1; st.kind = KIND_FAULT;
          nextState = S_IDLE;
        end else if (!busy && drq) begin
          nextState = S_XFER;
        end else if (timerLast) begin
          st.finishErr = 1'b1; st.kind = KIND_TIMEOUT;
          nextState = S_IDLE;
        end else begin
          st.tick = 1'b1;
        end
      end
      S_XFER: begin
        st.access = 1'b1; st.isWrite = curWrite; st.sel = SEL_DATA;
        st.wordStep = 1'b1;
        if (wordLast) nextState = sectorLast ? S_WAITEND : S_WAITDRQ;
      end
      S_WAITEND: begin
        st.access = 1'b1; st.sel = SEL_CMDSTAT;
        if (!busy && errBit) begin
          nextState = S_GETERR;
        end else if (!busy && fault) begin
          st.finishErr = 1'b1; st.kind = KIND_FAULT;
          nextState = S_IDLE;
        end else if (!busy) begin
          st.finishOk = 1'b1;
          nextState = S_IDLE;
        end else if (timerLast) begin
          st.finishErr = 1'b1; st.kind = KIND_TIMEOUT;
          nextState = S_IDLE;
        end else begin
          st.tick = 1'b1;
        end
      end
      S_GETERR: begin
        st.access = 1'b1; st.sel = SEL_ERRREG;
        st.grabErr = 1'b1; st.finishErr = 1'b1; st.kind = KIND_DRIVE;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R2: parameter programming begins only after a ready status read
  a_r2_params_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COUNT) |-> ($past(state) == S_WAITRDY &&
                            !$past(status[ST_BUSY]) && $past(status[ST_READY])));

  // R11: a new request is never accepted mid-sequence
  a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    (idle && reqValid) |=> !idle);

endmodule

// File: rtl/pio_seq_dp.sv
module pio_seq_dp
  import pio_seq_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int TIMEOUT_POLLS    = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic        reqWrite,
  input  logic        reqDrive,
  input  logic [27:0] reqLba,
  input  logic [7:0]  reqCount,
  input  logic [15:0] wrData,
  input  logic [15:0] devRdata,
  output logic        curWrite,
  output logic        wordLast,
  output logic        sectorLast,
  output logic        timerLast,
  output logic [9:0]  devAddr,
  output logic        devWr,
  output logic        devRd,
  output logic [15:0] devWdata,
  output logic        wrTake,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        done,
  output logic        err,
  output logic [1:0]  errKind,
  output logic [7:0]  errDetail
);

  localparam int WW = (WORDS_PER_SECTOR > 1) ? $clog2(WORDS_PER_SECTOR) : 1;
  localparam int TW = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [WW-1:0] WORD_MAX  = WW'(WORDS_PER_SECTOR - 1);
  localparam logic [TW-1:0] TIMER_MAX = TW'(TIMEOUT_POLLS - 1);

  logic        drvQ;
  logic [27:0] lbaQ;
  logic [7:0]  cntQ;
  logic [WW-1:0] wordCnt;
  logic [8:0]  secLeft;
  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWrite <= 1'b0; drvQ <= 1'b0; lbaQ <= '0; cntQ <= '0;
    end else if (st.load) begin
      curWrite <= reqWrite; drvQ <= reqDrive; lbaQ <= reqLba; cntQ <= reqCount;
    end
  end

  // word and sector bookkeeping; a zero count stands for 256 sectors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0; secLeft <= '0;
    end else if (st.load) begin
      wordCnt <= '0;
      secLeft <= (reqCount == 8'd0) ? 9'd256 : {1'b0, reqCount};
    end else if (st.wordStep) begin
      if (wordCnt == WORD_MAX) begin
        wordCnt <= '0;
        secLeft <= secLeft - 9'd1;
      end else begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  assign wordLast   = (wordCnt == WORD_MAX);
  assign sectorLast = (secLeft == 9'd1);

  always_ff @(posedge clk) begin
    if (!rstN)        timer <= '0;
    else if (st.tick) timer <= timer + 1'b1;
    else              timer <= '0;
  end
  assign timerLast = (timer == TIMER_MAX);

  // device port
  logic [7:0] headByte;
  assign headByte = {3'b111, drvQ, lbaQ[27:24]};

  always_comb begin
    case (st.sel)
      SEL_DEVCTL:  devWdata = {8'h00, DEVCTL_VAL};
      SEL_COUNT:   devWdata = {8'h00, cntQ};
      SEL_LBA0:    devWdata = {8'h00, lbaQ[7:0]};
      SEL_LBA1:    devWdata = {8'h00, lbaQ[15:8]};
      SEL_LBA2:    devWdata = {8'h00, lbaQ[23:16]};
      SEL_HEAD:    devWdata = {8'h00, headByte};
      SEL_CMDSTAT: devWdata = {8'h00, curWrite ? OPC_WRITE : OPC_READ};
      SEL_DATA:    devWdata = wrData;
      default:     devWdata = 16'h0000;
    endcase
  end

  assign devAddr = st.access ? selAddr(st.sel) : 10'h000;
  assign devWr   = st.access && st.isWrite;
  assign devRd   = st.access && !st.isWrite;
  assign wrTake  = st.wordStep && st.isWrite;
  assign rdValid = st.wordStep && !st.isWrite;
  assign rdData  = devRdata;

  // completion pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; err <= 1'b0; errKind <= 2'd0; errDetail <= 8'h00;
    end else begin
      done <= st.finishOk;
      err  <= st.finishErr;
      if (st.finishErr) begin
        errKind   <= st.kind;
        errDetail <= st.grabErr ? devRdata[7:0] : 8'h00;
      end
    end
  end

  // R11: completions are exclusive single pulses
  a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_err_single: assert property (@(posedge clk) disable iff (!rstN)
    err |=> !err);

  // R8: error register is fetched only right after a status read
  a_r8_errreg_after_status: assert property (@(posedge clk) disable iff (!rstN)
    (devRd && devAddr == ADR_ERRREG) |->
      $past(devRd && devAddr == ADR_CMDST && devRdata[ST_ERROR]));

  // R4: a burst of data accesses starts only after a DRQ status read
  a_r4_data_after_drq: assert property (@(posedge clk) disable iff (!rstN)
    ((devRd || devWr) && devAddr == ADR_DATA &&
     !$past((devRd || devWr) && devAddr == ADR_DATA)) |->
      $past(devRd && devAddr == ADR_CMDST && devRdata[ST_DRQ] && !devRdata[ST_BUSY]));

  // R5: write words go out on the data port in the cycle they are taken
  a_r5_take_on_data_write: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> (devWr && devAddr == ADR_DATA && devWdata == wrData));

  // R10: the poll timer never passes its limit
  a_r10_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TIMER_MAX);

endmodule

// File: rtl/pio_disk_seq.sv
module pio_disk_seq
  import pio_seq_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int TIMEOUT_POLLS    = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic        reqDrive,
  input  logic [27:0] reqLba,
  input  logic [7:0]  reqCount,
  input  logic [15:0] wrData,
  output logic        wrTake,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        done,
  output logic        err,
  output logic [1:0]  errKind,
  output logic [7:0]  errDetail,
  output logic [9:0]  devAddr,
  output logic        devWr,
  output logic        devRd,
  output logic [15:0] devWdata,
  input  logic [15:0] devRdata
);

  strobe_t stb;
  logic curWrite, wordLast, sectorLast, timerLast;

  pio_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .curWrite(curWrite),
    .status(devRdata[7:0]), .wordLast(wordLast), .sectorLast(sectorLast),
    .timerLast(timerLast), .idle(reqReady), .st(stb)
  );

  pio_seq_dp #(
    .WORDS_PER_SECTOR(WORDS_PER_SECTOR), .TIMEOUT_POLLS(TIMEOUT_POLLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(stb), .reqWrite(reqWrite), .reqDrive(reqDrive),
    .reqLba(reqLba), .reqCount(reqCount), .wrData(wrData), .devRdata(devRdata),
    .curWrite(curWrite), .wordLast(wordLast), .sectorLast(sectorLast),
    .timerLast(timerLast), .devAddr(devAddr), .devWr(devWr), .devRd(devRd),
    .devWdata(devWdata), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .done(done), .err(err), .errKind(errKind), .errDetail(errDetail)
  );

endmodule

// File: tb/sim_pio_disk_seq.sv
module sim_pio_disk_seq;

  localparam int WORDS = 256;
  localparam int TMO   = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        reqValid = 1'b0, reqWrite = 1'b0, reqDrive = 1'b0;
  logic [27:0] reqLba = '0;
  logic [7:0]  reqCount = '0;
  logic [15:0] wrData, rdData, devWdata, devRdata;
  logic        reqReady, wrTake, rdValid, done, err, devWr, devRd;
  logic [1:0]  errKind;
  logic [7:0]  errDetail;
  logic [9:0]  devAddr;

  pio_disk_seq #(.WORDS_PER_SECTOR(WORDS), .TIMEOUT_POLLS(TMO)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqDrive(reqDrive), .reqLba(reqLba), .reqCount(reqCount),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .done(done), .err(err), .errKind(errKind), .errDetail(errDetail),
    .devAddr(devAddr), .devWr(devWr), .devRd(devRd), .devWdata(devWdata),
    .devRdata(devRdata)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [15:0] wpat(int s, int w);
    return 16'((s * 37 + w * 5) ^ 16'h3C00);
  endfunction
  function automatic logic [15:0] rpat(int s, int w);
    return 16'((s * 91 + w * 3) ^ 16'hA5C3);
  endfunction

  // ---------------- device model ----------------
  int         busyLeft = 0;
  logic [7:0] statAfter = 8'h40;
  int         cmdBusy = 0, endBusy = 0, nsec = 1;
  logic [7:0] cmdStat = 8'h48, endStat = 8'h40, errVal = 8'h00;
  int         secIdx = 0, wordIdx = 0;

  always_comb begin
    case (devAddr)
      10'h1F7: devRdata = {8'h00, (busyLeft > 0) ? 8'h80 : statAfter};
      10'h1F1: devRdata = {8'h00, errVal};
      10'h1F0: devRdata = rpat(secIdx, wordIdx);
      default: devRdata = 16'h0000;
    endcase
  end
  assign wrData = wpat(secIdx, wordIdx);

  always @(posedge clk) begin
    if (devRd && devAddr == 10'h1F7 && busyLeft > 0) busyLeft <= busyLeft - 1;
    if (devWr && devAddr == 10'h1F7) begin
      busyLeft <= cmdBusy; statAfter <= cmdStat; secIdx <= 0; wordIdx <= 0;
    end
    if ((devRd || devWr) && devAddr == 10'h1F0) begin
      if (wordIdx == WORDS - 1) begin
        wordIdx <= 0;
        secIdx  <= secIdx + 1;
        if (secIdx + 1 == nsec) begin busyLeft <= endBusy; statAfter <= endStat; end
        else begin busyLeft <= cmdBusy; statAfter <= 8'h48; end
      end else begin
        wordIdx <= wordIdx + 1;
      end
    end
  end

  // ---------------- reference model: expected access list ----------------
  typedef struct {
    int         kind;   // 0 access, 1 done, 2 err
    bit         wr;
    logic [9:0] a;
    logic [15:0] d;
    bit         chkData;
    logic [1:0] ek;
    logic [7:0] ed;
    string      req;
  } exp_t;
  exp_t q[$];

  task automatic pushAcc(bit wr, logic [9:0] a, logic [15:0] d, bit chk, string r);
    exp_t e;
    e.kind = 0; e.wr = wr; e.a = a; e.d = d; e.chkData = chk; e.ek = 0; e.ed = 0; e.req = r;
    q.push_back(e);
  endtask
  task automatic pushEnd(int k, logic [1:0] ek, logic [7:0] ed, string r);
    exp_t e;
    e.kind = k; e.wr = 0; e.a = 0; e.d = 0; e.chkData = 0; e.ek = ek; e.ed = ed; e.req = r;
    q.push_back(e);
  endtask

  task automatic fail(string r, string what, int act, int expv);
    fails++;
    $display("FAIL %s %s: actual %0h expected %0h", r, what, act, expv);
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (q.size() > 0 && q[0].kind != 0) begin
        checks++;
        if (devRd || devWr) fail(q[0].req, "access during completion", 32'(devAddr), 0);
        if (q[0].kind == 1) begin
          if (!done || err) fail(q[0].req, "done/err", {30'd0, done, err}, 2);
        end else begin
          if (!err || done) fail(q[0].req, "err/done", {30'd0, err, done}, 2);
          else if (errKind != q[0].ek || errDetail != q[0].ed)
            fail(q[0].req, "errKind/errDetail", {22'd0, errKind, errDetail},
                 {22'd0, q[0].ek, q[0].ed});
        end
        void'(q.pop_front());
      end else begin
        if (done || err) begin
          checks++;
          fail("R11", "unexpected completion", {30'd0, done, err}, 0);
        end
        if (devRd || devWr) begin
          checks++;
          if (q.size() == 0) begin
            fail("R11", "access while idle", 32'(devAddr), 0);
          end else begin
            if (devWr != q[0].wr || devAddr != q[0].a)
              fail(q[0].req, "access wr/addr", {21'd0, devWr, devAddr},
                   {21'd0, q[0].wr, q[0].a});
            else if (q[0].chkData && devWr && devWdata != q[0].d)
              fail(q[0].req, "write value", 32'(devWdata), 32'(q[0].d));
            else if (q[0].a == 10'h1F0 && !devWr && (!rdValid || rdData != q[0].d))
              fail("R5", "read word", {15'd0, rdValid, rdData}, {15'd1, q[0].d});
            if (q[0].a == 10'h1F0 && (wrTake != devWr))
              fail("R5", "wrTake", 32'(wrTake), 32'(devWr));
            void'(q.pop_front());
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic runReq(bit wr, bit drv, logic [27:0] lba, logic [7:0] cnt,
                        int sBusy, int cBusy, logic [7:0] cStat,
                        int eBusy, logic [7:0] eStat, logic [7:0] eVal);
    int n;
    int limit;
    n = (cnt == 0) ? 256 : int'(cnt);
    busyLeft = sBusy; statAfter = 8'h40;
    cmdBusy = cBusy; cmdStat = cStat; endBusy = eBusy; endStat = eStat;
    errVal = eVal; nsec = n;
    // R1: control register first
    pushAcc(1, 10'h3F6, 16'h000A, 1, "R1");
    // R2 / R10: ready wait
    if (sBusy >= TMO) begin
      for (int i = 0; i < TMO; i++) pushAcc(0, 10'h1F7, 0, 0, "R10");
      pushEnd(2, 2'd2, 8'h00, "R10");
    end else begin
      for (int i = 0; i <= sBusy; i++) pushAcc(0, 10'h1F7, 0, 0, "R2");
      // R3 / R6: parameters
      pushAcc(1, 10'h1F2, {8'h00, cnt}, 1, (cnt == 0) ? "R6" : "R3");
      pushAcc(1, 10'h1F3, {8'h00, lba[7:0]}, 1, "R3");
      pushAcc(1, 10'h1F4, {8'h00, lba[15:8]}, 1, "R3");
      pushAcc(1, 10'h1F5, {8'h00, lba[23:16]}, 1, "R3");
      pushAcc(1, 10'h1F6, {8'h00, 3'b111, drv, lba[27:24]}, 1, "R3");
      pushAcc(1, 10'h1F7, wr ? 16'h0030 : 16'h0020, 1, "R3");
      if (cBusy >= TMO) begin
        for (int i = 0; i < TMO; i++) pushAcc(0, 10'h1F7, 0, 0, "R10");
        pushEnd(2, 2'd2, 8'h00, "R10");
      end else if (cStat[0]) begin
        for (int i = 0; i <= cBusy; i++) pushAcc(0, 10'h1F7, 0, 0, "R8");
        pushAcc(0, 10'h1F1, 0, 0, "R8");
        pushEnd(2, 2'd0, eVal, "R8");
      end else begin
        for (int s = 0; s < n; s++) begin
          for (int i = 0; i <= cBusy; i++) pushAcc(0, 10'h1F7, 0, 0, "R4");
          for (int w = 0; w < WORDS; w++)
            pushAcc(wr, 10'h1F0, wr ? wpat(s, w) : rpat(s, w), 1,
                    (cnt == 0) ? "R6" : "R4");
        end
        for (int i = 0; i <= eBusy; i++) pushAcc(0, 10'h1F7, 0, 0, "R7");
        if (eStat[0]) begin
          pushAcc(0, 10'h1F1, 0, 0, "R8");
          pushEnd(2, 2'd0, eVal, "R8");
        end else if (eStat[5]) pushEnd(2, 2'd1, 8'h00, "R9");
        else pushEnd(1, 2'd0, 8'h00, "R7");
      end
    end
    // issue
    @(negedge clk);
    checks++;
    if (!reqReady) fail("R11", "reqReady before request", 0, 1);
    reqValid = 1'b1; reqWrite = wr; reqDrive = drv; reqLba = lba; reqCount = cnt;
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (reqReady) fail("R11", "reqReady while busy", 1, 0);
    limit = cycle + 80000;
    while (q.size() > 0 && cycle < limit && cycle < 195000) @(negedge clk);
    if (q.size() > 0) begin
      checks++;
      fail("R11", "watchdog, expected items left", q.size(), 0);
      q.delete();
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    checks++;
    if (!reqReady || done || err || devRd || devWr || wrTake || rdValid)
      fail("R11", "reset outputs", {25'd0, reqReady, done, err, devRd, devWr, wrTake, rdValid},
           32'h40);
    rstN = 1'b1;
    @(negedge clk);
    // R2 R4 R5 R7: one-sector read, primary drive, short waits
    runReq(0, 0, 28'h0123456, 8'd1, 3, 2, 8'h48, 1, 8'h50, 8'h00);
    // R3 R5 R7: two-sector write, secondary drive, upper LBA bits
    runReq(1, 1, 28'hABCDEF1, 8'd2, 0, 0, 8'h48, 0, 8'h40, 8'h00);
    // R8: ERROR at end of read, error register value 0x10
    runReq(0, 0, 28'h0000010, 8'd1, 1, 1, 8'h48, 2, 8'h41, 8'h10);
    // R8: ERROR together with DRQ after the opcode, no data moved
    runReq(0, 1, 28'h7777777, 8'd3, 0, 1, 8'h49, 0, 8'h40, 8'h04);
    // R9: FAULT at end of write
    runReq(1, 0, 28'h0F0F0F0, 8'd1, 0, 0, 8'h48, 0, 8'h60, 8'h00);
    // R10: drive never becomes ready
    runReq(0, 0, 28'h0000001, 8'd1, 1000, 0, 8'h48, 0, 8'h40, 8'h00);
    // R10: success on the last permitted poll
    runReq(1, 1, 28'h1234567, 8'd1, TMO - 1, TMO - 1, 8'h48, 0, 8'h40, 8'h00);
    // R10: DRQ never arrives after the opcode
    runReq(1, 0, 28'h0000002, 8'd1, 0, 1000, 8'h48, 0, 8'h40, 8'h00);
    // R6: count 0 means 256 sectors
    runReq(0, 1, 28'h0400000, 8'd0, 0, 0, 8'h48, 0, 8'h40, 8'h00);
    // R11: idle after the last request
    checks++;
    if (!reqReady) fail("R11", "reqReady at end", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd199000);
    fails++;
    $display("FAIL R11 watchdog expired: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule